// File: doc/BRIEF.md
# Direct-Indexed Address Translation Cache

This block sits between an address-generating core and its page-table walker and remembers recent 4 KiB page translations. A lookup presents a 32-bit linear address and, in the same cycle, the block reports whether it holds a translation. On a hit it also returns the physical address. On a miss the walker resolves the address and then installs the result through the update port, supplying the linear page number, the physical frame number and the global marking taken from bit 8 of the final table entry.

There is no associative search. Five linear address bits pick exactly one of 32 slots, and the remaining upper bits form a short tag that is compared against the stored one. Three maintenance operations keep the cache coherent with the page tables, and each completes in one clock: clear everything, clear every slot not marked global, and drop the single slot that holds a given page.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, so every lookup returns lk_hit = 0 and lk_paddr = 0 until an update is made.
- R2: A linear address selects exactly one slot, with 32 slots arranged as 8 sets by 4 ways. The set is address bits 14:12 and the way is address bits 16:15. Addresses that differ in any of bits 16:12 never share a slot.
- R3: A lookup hits only when the selected slot is valid and its stored tag equals address bits 31:17. On a hit lk_paddr is the stored frame in bits 31:12 and lookup address bits 11:0 in bits 11:0. On a miss lk_hit = 0 and lk_paddr = 0.
- R4: An update always overwrites the slot selected by upd_page. It marks the slot valid and stores the tag from upd_page and the frame from upd_frame, replacing any earlier occupant with a different tag.
- R5: An update stores upd_global (bit 8 of the table entry) as the slot's global mark, and writes 0 when it is clear, so a global mark from an earlier occupant does not survive.
- R6: flush_all invalidates every slot, global or not, in a single cycle.
- R7: flush_local invalidates only slots whose global mark is 0. Global slots keep hitting with their old frame.
- R8: inval_en invalidates the slot selected by inval_page only when that slot is valid and its tag equals inval_page bits 19:5. Otherwise no slot changes.
- R9: Lookup is combinational. A lookup in the same cycle as an update of its slot returns the old contents, and the new contents are visible from the next cycle.
- R10: When an update and any invalidation act on the same slot in one cycle, the update wins and the slot is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Translation found for lk_addr |
| lk_paddr | output | 32 | Physical address on a hit, zero otherwise |
| upd_en | input | 1 | Install a translation this cycle |
| upd_page | input | 20 | Linear page number (address bits 31:12) being installed |
| upd_frame | input | 20 | Physical frame number (table entry bits 31:12) |
| upd_global | input | 1 | Global mark, from table entry bit 8 |
| flush_all | input | 1 | Invalidate every slot |
| flush_local | input | 1 | Invalidate every slot without the global mark |
| inval_en | input | 1 | Invalidate one page if it is cached |
| inval_page | input | 20 | Linear page number to invalidate |

## Verification
The bench targets tag aliasing, where two pages that share bits 16:12 evict each other. A design that indexed or compared the wrong bits would return a stale frame for the evicted page. It also checks that a global mark does not outlive its slot: reinstalling a slot with the mark clear and then doing a local flush must remove it, and a design that only ever set the mark would keep hitting. Single-page invalidation is tested with a matching slot and with a tag mismatch, where an unconditional clear would drop a live translation. The same-cycle cases are covered too: a lookup racing an update must see the old frame, and an update racing a flush must survive. Random mixes of all operations are compared against a bench model throughout.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Maintenance request presented to the slot store in one cycle.
  typedef struct packed {
    logic all;     // drop every slot
    logic local_;  // drop slots without the global mark
    logic page;    // drop one slot on tag match
  } xlat_maint_t;

endpackage

// File: rtl/xlat_page_split.sv
// Splits a linear page number into slot index {way, set} and tag.
module xlat_page_split #(
  parameter int VPN_W    = 20,
  parameter int SET_BITS = 3,
  parameter int WAY_BITS = 2,
  localparam int IDX_W   = SET_BITS + WAY_BITS,
  localparam int TAG_W   = VPN_W - IDX_W
) (
  input  logic [VPN_W-1:0] page,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  logic [SET_BITS-1:0] set_sel;
  logic [WAY_BITS-1:0] way_sel;

  always_comb begin
    set_sel = page[SET_BITS-1:0];
    way_sel = page[IDX_W-1:SET_BITS];
    idx     = {way_sel, set_sel};
    tag     = page[VPN_W-1:IDX_W];
  end

endmodule

// File: rtl/xlat_slot_store.sv
// Slot storage: valid/global flip-flops with reset, tag/frame data without.
module xlat_slot_store
  import xlat_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int TAG_W   = 15,
  parameter int FRAME_W = 20,
  localparam int N_SLOT = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [FRAME_W-1:0] rd_frame,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_global,
  input  xlat_maint_t        maint,
  input  logic [IDX_W-1:0]   inv_idx,
  input  logic [TAG_W-1:0]   inv_tag
);

  logic [N_SLOT-1:0]  valid_q, valid_d;
  logic [N_SLOT-1:0]  glob_q, glob_d;
  logic [TAG_W-1:0]   tag_q   [N_SLOT];
  logic [FRAME_W-1:0] frame_q [N_SLOT];

  // next state for the per-slot flags
  always_comb begin
    for (int s = 0; s < N_SLOT; s++) begin
      logic sel, drop;
      sel  = wr_en && (wr_idx == IDX_W'(s));
      drop = maint.all
          || (maint.local_ && !glob_q[s])
          || (maint.page && (inv_idx == IDX_W'(s)) && valid_q[s]
              && (tag_q[s] == inv_tag));
      if (sel) begin
        valid_d[s] = 1'b1;
        glob_d[s]  = wr_global;
      end else begin
        valid_d[s] = valid_q[s] && !drop;
        glob_d[s]  = glob_q[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else begin
      valid_q <= valid_d;
      glob_q  <= glob_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      frame_q[wr_idx] <= wr_frame;
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_frame = frame_q[rd_idx];
  end

  a_r4_update_installs: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))
               && (frame_q[$past(wr_idx)] == $past(wr_frame))));

  a_r5_global_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (glob_q[$past(wr_idx)] == $past(wr_global)));

  a_r6_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (maint.all && !wr_en) |=> (valid_q == '0));

  a_r7_only_global_left: assert property (@(posedge clk) disable iff (!rst_n)
    (maint.local_ && !wr_en) |=> ((valid_q & ~glob_q) == '0));

  a_r8_page_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (maint.page && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag)
     && !(wr_en && (wr_idx == inv_idx))) |=> !valid_q[$past(inv_idx)]);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SET_BITS  = 3,
  parameter int WAY_BITS  = 2,
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int IDX_W    = SET_BITS + WAY_BITS,
  localparam int TAG_W    = VPN_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_paddr,
  input  logic              upd_en,
  input  logic [VPN_W-1:0]  upd_page,
  input  logic [VPN_W-1:0]  upd_frame,
  input  logic              upd_global,
  input  logic              flush_all,
  input  logic              flush_local,
  input  logic              inval_en,
  input  logic [VPN_W-1:0]  inval_page
);

  logic [IDX_W-1:0] lk_idx, up_idx, iv_idx;
  logic [TAG_W-1:0] lk_tag, up_tag, iv_tag;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [VPN_W-1:0] rd_frame;
  xlat_maint_t      maint;

  xlat_page_split #(.VPN_W(VPN_W), .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) i_split_lk (
    .page(lk_addr[ADDR_W-1:PAGE_BITS]), .idx(lk_idx), .tag(lk_tag));
  xlat_page_split #(.VPN_W(VPN_W), .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) i_split_up (
    .page(upd_page), .idx(up_idx), .tag(up_tag));
  xlat_page_split #(.VPN_W(VPN_W), .SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) i_split_iv (
    .page(inval_page), .idx(iv_idx), .tag(iv_tag));

  always_comb begin
    maint.all    = flush_all;
    maint.local_ = flush_local;
    maint.page   = inval_en;
  end

  xlat_slot_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .FRAME_W(VPN_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (lk_idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_frame  (rd_frame),
    .wr_en     (upd_en),
    .wr_idx    (up_idx),
    .wr_tag    (up_tag),
    .wr_frame  (upd_frame),
    .wr_global (upd_global),
    .maint     (maint),
    .inv_idx   (iv_idx),
    .inv_tag   (iv_tag)
  );

  always_comb begin
    lk_hit   = rd_valid && (rd_tag == lk_tag);
    lk_paddr = lk_hit ? {rd_frame, lk_addr[PAGE_BITS-1:0]} : '0;
  end

endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        upd_en;
  logic [19:0] upd_page, upd_frame, inval_page;
  logic        upd_global, flush_all, flush_local, inval_en;

  int checks = 0;
  int errors = 0;

  // reference state
  bit          m_valid [32];
  bit          m_glob  [32];
  logic [14:0] m_tag   [32];
  logic [19:0] m_frame [32];

  always #2.5 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .upd_en(upd_en), .upd_page(upd_page), .upd_frame(upd_frame), .upd_global(upd_global),
    .flush_all(flush_all), .flush_local(flush_local), .inval_en(inval_en),
    .inval_page(inval_page));

  // R2: slot = {addr[16:15], addr[14:12]}, tag = addr[31:17]
  function automatic int slot_of(logic [31:0] a);
    return int'(a[16:12]);
  endfunction

  function automatic logic [31:0] exp_paddr(logic [31:0] a, output bit hit);
    int s = slot_of(a);
    hit = m_valid[s] && (m_tag[s] == a[31:17]);
    return hit ? {m_frame[s], a[11:0]} : 32'h0;
  endfunction

  task automatic expect_lookup(logic [31:0] a, string req);
    bit eh;
    logic [31:0] ep;
    lk_addr = a;
    #1;
    ep = exp_paddr(a, eh);
    checks++;
    if (lk_hit !== eh || lk_paddr !== ep) begin
      errors++;
      $display("FAIL %s addr=%h actual hit=%0b paddr=%h expected hit=%0b paddr=%h",
               req, a, lk_hit, lk_paddr, eh, ep);
    end
  endtask

  // one clock of operations; the model applies R10 precedence, then R6, R7, R8
  task automatic cycle_op(bit u, logic [31:0] ua, logic [19:0] uf, bit ug,
                          bit fa, bit fl, bit iv, logic [31:0] ia);
    @(negedge clk);
    upd_en = u; upd_page = ua[31:12]; upd_frame = uf; upd_global = ug;
    flush_all = fa; flush_local = fl; inval_en = iv; inval_page = ia[31:12];
    @(posedge clk);
    for (int s = 0; s < 32; s++) begin
      if (u && slot_of(ua) == s) begin
        m_valid[s] = 1; m_glob[s] = ug; m_tag[s] = ua[31:17]; m_frame[s] = uf;
      end else if (fa || (fl && !m_glob[s])
                   || (iv && slot_of(ia) == s && m_valid[s] && m_tag[s] == ia[31:17])) begin
        m_valid[s] = 0;
      end
    end
    #1;
    upd_en = 0; flush_all = 0; flush_local = 0; inval_en = 0;
  endtask

  task automatic install(logic [31:0] a, logic [19:0] f, bit g);
    cycle_op(1, a, f, g, 0, 0, 0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pc, pd, pe, pf;
    bit eh;
    logic [14:0] tagpool [4];
    void'($urandom(32'h1d2c3b4a));
    for (int s = 0; s < 32; s++) m_valid[s] = 0;
    rst_n = 0; lk_addr = 0; upd_en = 0; upd_page = 0; upd_frame = 0; upd_global = 0;
    flush_all = 0; flush_local = 0; inval_en = 0; inval_page = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: everything misses after reset
    expect_lookup(32'h0000_0000, "R1");
    expect_lookup(32'hFFFF_FFFF, "R1");
    expect_lookup(32'h1234_5678, "R1");

    // R3 R4: install and hit with offset pass-through
    pa = 32'h1234_5678;
    install(pa, 20'hABCDE, 0);
    expect_lookup(pa, "R3");
    expect_lookup(pa ^ 32'h0000_0ABC, "R3");
    expect_lookup(pa ^ 32'h0002_0000, "R3");  // same slot, tag differs
    expect_lookup(pa ^ 32'h0000_1000, "R2");  // neighbour slot
    expect_lookup(pa ^ 32'h0000_8000, "R2");  // other way, same set

    // R9: lookup racing an update sees old frame
    @(negedge clk);
    upd_en = 1; upd_page = pa[31:12]; upd_frame = 20'h11111; upd_global = 0;
    lk_addr = pa; #1;
    checks++;
    if (lk_paddr !== 32'hABCD_E678) begin
      errors++;
      $display("FAIL R9 same-cycle actual %h expected %h", lk_paddr, 32'hABCD_E678);
    end
    @(posedge clk);
    m_frame[slot_of(pa)] = 20'h11111;
    #1; upd_en = 0;
    expect_lookup(pa, "R9");

    // R4: alias on the same slot evicts
    pb = pa ^ 32'h0002_0000;
    install(pb, 20'h22222, 0);
    expect_lookup(pb, "R4");
    expect_lookup(pa, "R4");

    // R7: local flush keeps global slot
    pc = 32'h0000_3ABC;
    install(pc, 20'h33333, 1);
    cycle_op(0, 0, 0, 0, 0, 1, 0, 0);
    expect_lookup(pc, "R7");
    expect_lookup(pb, "R7");

    // R5: reinstall with global clear, then local flush removes it
    install(pc, 20'h44444, 0);
    expect_lookup(pc, "R5");
    cycle_op(0, 0, 0, 0, 0, 1, 0, 0);
    expect_lookup(pc, "R5");

    // R8: mismatched invalidate keeps, matching one drops
    pd = 32'hCAFE_7123;
    install(pd, 20'h55555, 0);
    cycle_op(0, 0, 0, 0, 0, 0, 1, pd ^ 32'h0004_0000);
    expect_lookup(pd, "R8");
    cycle_op(0, 0, 0, 0, 0, 0, 1, pd);
    expect_lookup(pd, "R8");

    // R6: full flush removes global slots too
    pe = 32'h8000_1000;
    install(pe, 20'h66666, 1);
    expect_lookup(pe, "R6");
    cycle_op(0, 0, 0, 0, 1, 0, 0, 0);
    expect_lookup(pe, "R6");

    // R10: update beats a flush on its own slot
    pf = 32'h7777_F000;
    cycle_op(1, pf, 20'h77777, 0, 1, 1, 1, pf);
    expect_lookup(pf, "R10");

    // random mix against the model (R2 R3 R4 R5 R6 R7 R8)
    for (int t = 0; t < 4; t++) tagpool[t] = 15'($urandom);
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 39);
      logic [31:0] ra = {tagpool[$urandom_range(0, 3)], 17'($urandom)};
      logic [31:0] rb = {tagpool[$urandom_range(0, 3)], 17'($urandom)};
      if (op < 20)      install(ra, 20'($urandom), 1'($urandom));
      else if (op < 28) cycle_op(0, 0, 0, 0, 0, 0, 1, ra);
      else if (op < 31) cycle_op(0, 0, 0, 0, 0, 1, 0, 0);
      else if (op == 31) cycle_op(0, 0, 0, 0, 1, 0, 0, 0);
      expect_lookup(rb, "R3");
    end
    void'(exp_paddr(32'h0, eh));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule